// File: doc/BRIEF.md
# VLAN and Spanning-Tree Table Engine

This block keeps two small lookup tables for an Ethernet switch: a VLAN table and a spanning-tree state table. Each VLAN entry holds a 12-bit VLAN ID, a 12-bit filtering database ID, a 6-bit spanning-tree instance ID and a 2-bit member tag for every port. Each spanning-tree entry holds a 6-bit instance ID and a 2-bit port state for every port. Software drives the block through a small register bus. It first stages key, database, instance and per-port values in their registers. It then writes an operation word. The operation word can flush both tables, load or remove one entry, or ask for the next valid entry above a key.

While an operation runs, the engine steps through one table slot per clock. A busy bit stays high during the scan. The engine drops every register write that arrives while busy is high. When the scan ends, the engine updates the result registers and clears busy on the same clock edge. A load into a table with no free slot is dropped, and a sticky flag is raised in the status register.

Register map (rd_addr / wr_addr): 0 operation, 1 VID, 2 FID, 3 SID, 4 data A (ports 0-3), 5 data B (ports 4-7), 6 data C (ports 8-11), 7 status.

Top module: `vlan_stu_engine`

## Requirements
- R1: After reset, every register reads zero, busy is low, and both tables are empty, so a VLAN get-next returns with the valid flag clear.
- R2: The operation word carries busy in bit 15 and a code in bits 14:12. The codes are: 1 flush all, 3 VLAN load/purge, 4 VLAN get-next, 5 spanning-tree load/purge, 6 spanning-tree get-next. A word that does not have bit 15 set together with one of these codes is ignored. Reading the operation register returns busy in bit 15 and the last accepted code in bits 14:12.
- R3: Busy stays high for a fixed number of clock edges after the edge that accepts the operation: 1 for flush, VDEPTH for VLAN operations and SDEPTH for spanning-tree operations. Results are visible as soon as busy reads low.
- R4: While busy is high, writes to any register, including the operation register, have no effect.
- R5: The VID register holds the VLAN ID in bits 11:0 and a valid flag in bit 12. A VLAN load with valid set stores the FID, SID and member tags under that VID. If the VID is already present, the entry is overwritten in place.
- R6: A VLAN load with valid clear removes the entry for that VID.
- R7: VLAN get-next returns the valid entry with the lowest VID strictly above the VID register. It sets valid and returns that entry's VID, FID, SID and member tags. If no entry qualifies, it clears only the valid flag and leaves FID, SID and data unchanged.
- R8: Port i uses the nibble at bit (i mod 4)*4 of data register i/4. The member tag is in nibble bits 1:0 (0 unmodified, 1 untagged, 2 tagged, 3 non-member). The port state is in nibble bits 3:2 (0 disabled, 1 blocking, 2 learning, 3 forwarding). A load takes only its own lane. A get-next writes its own lane, writes zero to the other lane, and writes zero to nibbles with no port.
- R9: A spanning-tree load with VID bit 12 set stores the port states under the SID. With bit 12 clear, it removes that SID. Spanning-tree get-next returns the lowest valid SID strictly above the SID register, sets VID bit 12 and returns the port states. If no SID qualifies, it clears VID bit 12 and leaves everything else unchanged.
- R10: A spanning-tree get-next from SID 0x3F wraps and returns the lowest valid SID.
- R11: Flush all leaves both tables empty.
- R12: A load of a new key into a full table is dropped and sets status bit 0. The bit stays set until reset. An overwrite of a key that is already present still succeeds when the table is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Combinational read data |
| busy | output | 1 | Operation in progress |

## Verification
An operation is accepted on the edge that captures its write. Busy then falls after exactly 1 further edge for flush, VDEPTH (16) edges for VLAN operations and SDEPTH (8) edges for spanning-tree operations. The result registers change on that same final edge. The bench counts the edges until busy reads low and compares that count with the figure above. It reads results only after busy has fallen, sampling at the falling clock edge. In the busy-ignore case, the bench issues its stray writes in the first cycles of a scan and reads the registers only after the scan has finished.

// File: rtl/vlan_stu_engine.sv
module vlan_stu_engine #(
  parameter int NPORTS = 7,
  parameter int VDEPTH = 16,
  parameter int SDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        busy
);
  localparam int VIW = $clog2(VDEPTH);
  localparam int SIW = $clog2(SDEPTH);
  localparam int CW  = (VIW > SIW) ? VIW : SIW;
  localparam int TW  = 2 * NPORTS;
  localparam logic [CW-1:0] VLAST = CW'(VDEPTH - 1);
  localparam logic [CW-1:0] SLAST = CW'(SDEPTH - 1);

  localparam logic [2:0] OP_FLUSH = 3'd1, OP_VLOAD = 3'd3, OP_VNEXT = 3'd4,
                         OP_SLOAD = 3'd5, OP_SNEXT = 3'd6;
  localparam logic [2:0] A_OP = 3'd0, A_VID = 3'd1, A_FID = 3'd2, A_SID = 3'd3,
                         A_DA = 3'd4, A_DB = 3'd5, A_DC = 3'd6, A_STAT = 3'd7;

  logic [2:0]    op;
  logic [CW-1:0] cnt, hit_i, free_i;
  logic          hit_f, free_f, full_f;
  logic [12:0]   vid_r;
  logic [11:0]   fid_r;
  logic [5:0]    sid_r;
  logic [47:0]   dat;

  logic [VDEPTH-1:0] v_valid;
  logic [11:0]       v_vid [VDEPTH];
  logic [11:0]       v_fid [VDEPTH];
  logic [5:0]        v_sid [VDEPTH];
  logic [TW-1:0]     v_tag [VDEPTH];
  logic [SDEPTH-1:0] s_valid;
  logic [5:0]        s_sid [SDEPTH];
  logic [TW-1:0]     s_st  [SDEPTH];

  logic          is_stu, is_load, cur_v, sel, wrap, last, start;
  logic [11:0]   cur_k, key, best_k;
  logic          n_hit_f, n_free_f;
  logic [CW-1:0] n_hit_i, n_free_i;
  logic [VIW-1:0] hv, fv;
  logic [SIW-1:0] hs, fs;
  logic [TW-1:0] tag_in, st_in;
  logic [47:0]   vout, sout;

  assign is_stu  = (op == OP_SLOAD) || (op == OP_SNEXT);
  assign is_load = (op == OP_VLOAD) || (op == OP_SLOAD);
  assign cur_v   = is_stu ? s_valid[cnt[SIW-1:0]] : v_valid[cnt[VIW-1:0]];
  assign cur_k   = is_stu ? {6'd0, s_sid[cnt[SIW-1:0]]} : v_vid[cnt[VIW-1:0]];
  assign key     = is_stu ? {6'd0, sid_r} : vid_r[11:0];
  assign best_k  = is_stu ? {6'd0, s_sid[hit_i[SIW-1:0]]} : v_vid[hit_i[VIW-1:0]];
  assign wrap    = is_stu && (sid_r == 6'h3F);
  assign sel     = is_load ? (cur_v && cur_k == key)
                           : (cur_v && (cur_k > key || wrap) && (!hit_f || cur_k < best_k));
  assign n_hit_f  = hit_f | sel;
  assign n_hit_i  = sel ? cnt : hit_i;
  assign n_free_f = free_f | !cur_v;
  assign n_free_i = (!free_f && !cur_v) ? cnt : free_i;
  assign last     = (op == OP_FLUSH) || (cnt == (is_stu ? SLAST : VLAST));
  assign hv = n_hit_i[VIW-1:0];
  assign hs = n_hit_i[SIW-1:0];
  assign fv = n_free_i[VIW-1:0];
  assign fs = n_free_i[SIW-1:0];
  assign start = wr_en && !busy && wr_addr == A_OP && wr_data[15] &&
                 (wr_data[14:12] == OP_FLUSH || wr_data[14:12] == OP_VLOAD ||
                  wr_data[14:12] == OP_VNEXT || wr_data[14:12] == OP_SLOAD ||
                  wr_data[14:12] == OP_SNEXT);

  always_comb begin
    tag_in = '0;
    st_in  = '0;
    vout   = '0;
    sout   = '0;
    for (int i = 0; i < NPORTS; i++) begin
      tag_in[2*i +: 2]   = dat[4*i +: 2];
      st_in[2*i +: 2]    = dat[4*i+2 +: 2];
      vout[4*i +: 2]     = v_tag[hv][2*i +: 2];
      sout[4*i+2 +: 2]   = s_st[hs][2*i +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op <= '0; cnt <= '0;
      hit_f <= 1'b0; hit_i <= '0; free_f <= 1'b0; free_i <= '0;
      full_f <= 1'b0;
      vid_r <= '0; fid_r <= '0; sid_r <= '0; dat <= '0;
      v_valid <= '0; s_valid <= '0;
    end else begin
      if (wr_en && !busy) begin
        case (wr_addr)
          A_VID: vid_r <= wr_data[12:0];
          A_FID: fid_r <= wr_data[11:0];
          A_SID: sid_r <= wr_data[5:0];
          A_DA:  dat[15:0]  <= wr_data;
          A_DB:  dat[31:16] <= wr_data;
          A_DC:  dat[47:32] <= wr_data;
          default: ;
        endcase
      end
      if (start) begin
        busy <= 1'b1; op <= wr_data[14:12]; cnt <= '0;
        hit_f <= 1'b0; free_f <= 1'b0;
      end
      if (busy) begin
        hit_f <= n_hit_f; hit_i <= n_hit_i;
        free_f <= n_free_f; free_i <= n_free_i;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          case (op)
            OP_FLUSH: begin
              v_valid <= '0;
              s_valid <= '0;
            end
            OP_VLOAD: begin
              if (!vid_r[12]) begin
                if (n_hit_f) v_valid[hv] <= 1'b0;
              end else if (n_hit_f) begin
                v_fid[hv] <= fid_r; v_sid[hv] <= sid_r; v_tag[hv] <= tag_in;
              end else if (n_free_f) begin
                v_valid[fv] <= 1'b1; v_vid[fv] <= vid_r[11:0];
                v_fid[fv] <= fid_r; v_sid[fv] <= sid_r; v_tag[fv] <= tag_in;
              end else begin
                full_f <= 1'b1;
              end
            end
            OP_VNEXT: begin
              if (n_hit_f) begin
                vid_r <= {1'b1, v_vid[hv]};
                fid_r <= v_fid[hv]; sid_r <= v_sid[hv]; dat <= vout;
              end else begin
                vid_r[12] <= 1'b0;
              end
            end
            OP_SLOAD: begin
              if (!vid_r[12]) begin
                if (n_hit_f) s_valid[hs] <= 1'b0;
              end else if (n_hit_f) begin
                s_st[hs] <= st_in;
              end else if (n_free_f) begin
                s_valid[fs] <= 1'b1; s_sid[fs] <= sid_r; s_st[fs] <= st_in;
              end else begin
                full_f <= 1'b1;
              end
            end
            OP_SNEXT: begin
              if (n_hit_f) begin
                vid_r[12] <= 1'b1; sid_r <= s_sid[hs]; dat <= sout;
              end else begin
                vid_r[12] <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_OP:    rd_data = {busy, op, 12'd0};
      A_VID:   rd_data = {3'd0, vid_r};
      A_FID:   rd_data = {4'd0, fid_r};
      A_SID:   rd_data = {10'd0, sid_r};
      A_DA:    rd_data = dat[15:0];
      A_DB:    rd_data = dat[31:16];
      A_DC:    rd_data = dat[47:32];
      default: rd_data = {15'd0, full_f};
    endcase
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_addr == A_OP && wr_data[15] && wr_data[14:12] == OP_VNEXT) |=> busy); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> !busy); // R3
  AST_IGNORE_FID: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && wr_en && wr_addr == A_FID) |=> $stable(fid_r)); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_FLUSH) |=> (v_valid == '0 && s_valid == '0)); // R11
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_f |=> full_f); // R12
endmodule

// File: tb/vlan_stu_engine_tb.sv
module vlan_stu_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;

  logic [2:0]  q_addr[$];
  logic [15:0] q_exp[$];
  string       q_req[$];
  logic [15:0] m_exp;
  string       m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_stu_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q_addr.size() > 0) begin
        rd_addr = q_addr.pop_front();
        m_exp = q_exp.pop_front();
        m_req = q_req.pop_front();
        #1;
        n_cmp++;
        if (rd_data !== m_exp) begin
          n_bad++;
          $display("FAIL %s: reg %0d actual %h expected %h", m_req, rd_addr, rd_data, m_exp);
        end
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [15:0] e, input string r);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_req.push_back(r);
  endtask

  task automatic drain();
    while (q_addr.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(input int pre, input int exp_n, input string r);
    int n;
    n = pre;
    while (busy) begin
      @(negedge clk);
      n++;
    end
    n_cmp++;
    if (n != exp_n) begin
      n_bad++;
      $display("FAIL %s: busy edges actual %0d expected %0d", r, n, exp_n);
    end
  endtask

  task automatic run_op(input logic [15:0] w, input int exp_n, input string r);
    wr(3'd0, w);
    wait_done(0, exp_n, r);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: busy actual %b expected 0", busy);
    end
    expect_reg(3'd0, 16'h0000, "R1");
    expect_reg(3'd1, 16'h0000, "R1");
    expect_reg(3'd2, 16'h0000, "R1");
    expect_reg(3'd4, 16'h0000, "R1");
    expect_reg(3'd7, 16'h0000, "R1");
    drain();
    run_op(16'hC000, 16, "R3");
    expect_reg(3'd1, 16'h0000, "R1");
    drain();

    // R5 R8: VLAN 100 with state lane noise, VLAN 5
    wr(3'd1, 16'h1064); wr(3'd2, 16'h0008); wr(3'd3, 16'h0000);
    wr(3'd4, 16'h323F); wr(3'd5, 16'h0323); wr(3'd6, 16'h0000);
    run_op(16'hB000, 16, "R3");
    wr(3'd1, 16'h1005); wr(3'd2, 16'h00AB); wr(3'd3, 16'h0002);
    wr(3'd4, 16'h1111); wr(3'd5, 16'h0222);
    run_op(16'hB000, 16, "R3");
    wr(3'd1, 16'h0000);
    run_op(16'hC000, 16, "R7");
    expect_reg(3'd1, 16'h1005, "R7");
    expect_reg(3'd2, 16'h00AB, "R5");
    expect_reg(3'd3, 16'h0002, "R5");
    expect_reg(3'd4, 16'h1111, "R8");
    expect_reg(3'd5, 16'h0222, "R8");
    expect_reg(3'd6, 16'h0000, "R8");
    drain();
    run_op(16'hC000, 16, "R7");
    expect_reg(3'd1, 16'h1064, "R7");
    expect_reg(3'd2, 16'h0008, "R5");
    expect_reg(3'd4, 16'h3233, "R8");
    expect_reg(3'd5, 16'h0323, "R8");
    drain();
    run_op(16'hC000, 16, "R7");
    expect_reg(3'd1, 16'h0064, "R7");
    expect_reg(3'd2, 16'h0008, "R7");
    drain();

    // R5 overwrite, R6 purge
    wr(3'd1, 16'h1005); wr(3'd2, 16'h00CD);
    run_op(16'hB000, 16, "R5");
    wr(3'd1, 16'h0000);
    run_op(16'hC000, 16, "R5");
    expect_reg(3'd1, 16'h1005, "R5");
    expect_reg(3'd2, 16'h00CD, "R5");
    drain();
    wr(3'd1, 16'h0005);
    run_op(16'hB000, 16, "R6");
    wr(3'd1, 16'h0000);
    run_op(16'hC000, 16, "R6");
    expect_reg(3'd1, 16'h1064, "R6");
    drain();

    // R9 R10 spanning-tree table
    wr(3'd1, 16'h1000); wr(3'd3, 16'h0003);
    wr(3'd4, 16'h048C); wr(3'd5, 16'h0CCC); wr(3'd6, 16'h0000);
    run_op(16'hD000, 8, "R3");
    wr(3'd3, 16'h000A); wr(3'd4, 16'h4447); wr(3'd5, 16'h0444);
    run_op(16'hD000, 8, "R9");
    wr(3'd1, 16'h0000); wr(3'd3, 16'h0003);
    run_op(16'hE000, 8, "R9");
    expect_reg(3'd1, 16'h1000, "R9");
    expect_reg(3'd3, 16'h000A, "R9");
    expect_reg(3'd4, 16'h4444, "R8");
    expect_reg(3'd5, 16'h0444, "R8");
    expect_reg(3'd6, 16'h0000, "R8");
    drain();
    run_op(16'hE000, 8, "R9");
    expect_reg(3'd1, 16'h0000, "R9");
    expect_reg(3'd3, 16'h000A, "R9");
    drain();
    wr(3'd3, 16'h003F);
    run_op(16'hE000, 8, "R10");
    expect_reg(3'd3, 16'h0003, "R10");
    expect_reg(3'd1, 16'h1000, "R10");
    expect_reg(3'd4, 16'h048C, "R10");
    expect_reg(3'd5, 16'h0CCC, "R10");
    drain();
    wr(3'd1, 16'h0000); wr(3'd3, 16'h0003);
    run_op(16'hD000, 8, "R9");
    wr(3'd3, 16'h003F);
    run_op(16'hE000, 8, "R9");
    expect_reg(3'd3, 16'h000A, "R9");
    drain();

    // R4 writes while busy are dropped
    wr(3'd1, 16'h0064); wr(3'd2, 16'h0111);
    wr(3'd0, 16'hC000);
    wr(3'd2, 16'h0222);
    wr(3'd0, 16'h9000);
    wait_done(2, 16, "R4");
    expect_reg(3'd2, 16'h0111, "R4");
    expect_reg(3'd0, 16'h4000, "R4");
    expect_reg(3'd1, 16'h0064, "R4");
    drain();
    // R2 unknown opcode ignored
    wr(3'd0, 16'hA000);
    n_cmp++;
    if (busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: busy actual %b expected 0", busy);
    end
    expect_reg(3'd0, 16'h4000, "R2");
    drain();
    wr(3'd1, 16'h0000);
    run_op(16'hC000, 16, "R4");
    expect_reg(3'd1, 16'h1064, "R4");
    drain();

    // R12 full table
    wr(3'd2, 16'h0020);
    for (int v = 1; v < 16; v++) begin
      wr(3'd1, 16'h1000 | 16'(v));
      run_op(16'hB000, 16, "R12");
    end
    expect_reg(3'd7, 16'h0000, "R12");
    drain();
    wr(3'd1, 16'h10C8);
    run_op(16'hB000, 16, "R12");
    expect_reg(3'd7, 16'h0001, "R12");
    drain();
    wr(3'd1, 16'h00C7);
    run_op(16'hC000, 16, "R12");
    expect_reg(3'd1, 16'h00C7, "R12");
    drain();
    wr(3'd1, 16'h1064); wr(3'd2, 16'h0077);
    run_op(16'hB000, 16, "R12");
    wr(3'd1, 16'h0063);
    run_op(16'hC000, 16, "R12");
    expect_reg(3'd1, 16'h1064, "R12");
    expect_reg(3'd2, 16'h0077, "R12");
    expect_reg(3'd7, 16'h0001, "R12");
    drain();

    // R11 flush
    run_op(16'h9000, 1, "R11");
    wr(3'd1, 16'h0000);
    run_op(16'hC000, 16, "R11");
    expect_reg(3'd1, 16'h0000, "R11");
    drain();
    wr(3'd1, 16'h0000); wr(3'd3, 16'h003F);
    run_op(16'hE000, 8, "R11");
    expect_reg(3'd1, 16'h0000, "R11");
    expect_reg(3'd7, 16'h0001, "R12");
    drain();

    summary();
  end
endmodule